// File: doc/BRIEF.md
# Multi-channel PWM controller

A bank of pulse-width-modulated outputs behind a simple read/write register bus. A shared word at offset 0x00 holds one run bit per channel. Each channel has its own register window at `BASE + n * STRIDE`. The window holds a control word with a 3-bit power-of-two clock divider, a period count and a high-time count. Both counts are stored as their value minus one.

Each running channel steps a prescaler on every input clock. The prescaler produces one count step every 2^D clocks. A channel state machine has three states. `CH_OFF` is stopped, with the output low. `CH_HIGH` is the leading part of a period, with the output high. `CH_LOW` is the trailing part, with the output low.

The state machine has these transitions:
- **start**: `CH_OFF` to `CH_HIGH`, taken when the run bit is seen.
- **fall**: `CH_HIGH` to `CH_LOW`, taken when the high count is used up before the period ends.
- **wrap**: `CH_HIGH` or `CH_LOW` back to `CH_HIGH`, taken at the end of the period.
- **stop**: any state to `CH_OFF`, taken when the run bit is cleared.

Divider, period and high count are copied into working registers only on start and wrap. Software can therefore rewrite them at any time without producing a broken cycle.

With the fixup parameter set, channels with an index above 2 move their period and high-count registers up by four bytes.

Top module: `pwm_bank`

## Requirements
- R1: A write to offset 0x00 stores bits [NCH-1:0] of the write data as the run mask, with bit n running channel n. A read of 0x00 returns that mask in bits [NCH-1:0], with all higher bits zero.
- R2: The window of channel n starts at BASE + n*STRIDE. The control word is at +0x00, the period at +0x2C and the high count at +0x30.
- R3: Control bits [2:0] hold the divider D, so that one count step spans 2^D input clocks (ratios 1 to 128). Control bit 15 is stored and reads back as written. All other control bits read 0.
- R4: The period register keeps bits [12:0] (value P) and reads the other bits as 0. A running channel repeats every (P+1)*2^D input clocks.
- R5: The high-count register keeps bits [12:0] (value T) and reads the other bits as 0. If T < P, the output is high for the first (T+1)*2^D clocks of each period and low for the rest.
- R6: If T >= P, the output stays high without a break. This includes T == P, where the end of the high time and the end of the period fall on the same count step.
- R7: A channel whose run bit is 0 drives its output low. After the clock edge that stores its run bit as 1, the next edge starts a period with the output high.
- R8: A new divider, period or high count written to a running channel changes nothing in the period in progress. It takes effect from the next period.
- R9: With ALT_DECODE set, channels with index greater than 2 decode the period at +0x30 and the high count at +0x34, and their +0x2C reads 0. Channels 0 to 2 keep the normal offsets.
- R10: A read of an unmapped offset returns 0, and a write to one changes no register. Unmapped offsets include holes inside a window and windows beyond channel NCH-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for bus, prescalers and counters |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| rd_en | input | 1 | Read strobe; rdata is valid in the same cycle |
| addr | input | AW | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, 0 when rd_en is low or the address is unmapped |
| pwm_o | output | NCH | One waveform output per channel |

## Verification
Two channel events can land on the same count step: the end of the high time (the fall transition) and the end of the period (the wrap transition). This happens exactly when T equals P, and it must resolve to wrap so that the output never dips. The bench provokes it with directed settings where T == P and random settings where T >= P. It judges the result by watching the output at every cycle across two periods.

A second collision comes from a bus write that lands while a period is in flight. The bench rewrites the period and high count just after a rising edge of the output. It then checks that the period in progress keeps its old length and that the following period has the new length and high time.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_EN,
        RK_CTRL,
        RK_PER,
        RK_THR
    } reg_kind_e;

    typedef enum logic [1:0] {
        CH_OFF,
        CH_HIGH,
        CH_LOW
    } chan_state_e;

    localparam int OFS_CTRL     = 'h00;
    localparam int OFS_PER      = 'h2C;
    localparam int OFS_THR      = 'h30;
    localparam int OFS_PER_ALT  = 'h30;
    localparam int OFS_THR_ALT  = 'h34;
    localparam int CTRL_KEEP    = 15;
    localparam int ALT_FIRST_CH = 3;

endpackage

// File: rtl/pwm_addr_dec.sv
module pwm_addr_dec
    import pwm_bank_pkg::*;
#(
    parameter int NCH        = 8,
    parameter int AW         = 12,
    parameter int BASE       = 'h10,
    parameter int STRIDE     = 'h40,
    parameter bit ALT_DECODE = 1'b0
) (
    input  logic [AW-1:0]                addr_i,
    output reg_kind_e                    kind_o,
    output logic [((NCH>1)?$clog2(NCH):1)-1:0] ch_o
);
    localparam int IW  = (NCH > 1) ? $clog2(NCH) : 1;
    localparam int SSH = $clog2(STRIDE);

    logic [AW-1:0] off, idx_full, sub, per_ofs, thr_ofs;
    logic          alt;

    always_comb begin
        off      = addr_i - AW'(BASE);
        idx_full = off >> SSH;
        sub      = off & AW'(STRIDE - 1);
        alt      = ALT_DECODE && (idx_full >= AW'(ALT_FIRST_CH));
        per_ofs  = alt ? AW'(OFS_PER_ALT) : AW'(OFS_PER);
        thr_ofs  = alt ? AW'(OFS_THR_ALT) : AW'(OFS_THR);
        ch_o     = idx_full[IW-1:0];
        kind_o   = RK_NONE;
        if (addr_i == '0) begin
            kind_o = RK_EN;
        end else if (addr_i >= AW'(BASE) && idx_full < AW'(NCH)) begin
            if (sub == AW'(OFS_CTRL))  kind_o = RK_CTRL;
            else if (sub == per_ofs)   kind_o = RK_PER;
            else if (sub == thr_ofs)   kind_o = RK_THR;
        end
    end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
    import pwm_bank_pkg::*;
#(
    parameter int CNTW = 13,
    parameter int DIVW = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en_i,
    input  logic [DIVW-1:0] div_i,
    input  logic [CNTW-1:0] per_i,
    input  logic [CNTW-1:0] thr_i,
    output logic            pwm_o
);
    localparam int PW = (1 << DIVW) - 1;

    chan_state_e     state;
    logic [CNTW-1:0] cnt, per_a, thr_a;
    logic [DIVW-1:0] div_a;
    logic [PW-1:0]   pre, pre_lim;
    logic            tick, wrap;

    always_comb begin
        pre_lim = ~({PW{1'b1}} << div_a);
        tick    = (pre == pre_lim);
        wrap    = tick && (cnt == per_a);
    end

    // state register: start / fall / wrap / stop
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= CH_OFF;
            cnt   <= '0;
            pre   <= '0;
            per_a <= '0;
            thr_a <= '0;
            div_a <= '0;
        end else if (!en_i) begin
            state <= CH_OFF;
            cnt   <= '0;
            pre   <= '0;
        end else begin
            unique case (state)
                CH_OFF: begin
                    state <= CH_HIGH;
                    cnt   <= '0;
                    pre   <= '0;
                    per_a <= per_i;
                    thr_a <= thr_i;
                    div_a <= div_i;
                end
                CH_HIGH, CH_LOW: begin
                    if (!tick) begin
                        pre <= pre + 1'b1;
                    end else if (wrap) begin
                        pre   <= '0;
                        state <= CH_HIGH;
                        cnt   <= '0;
                        per_a <= per_i;
                        thr_a <= thr_i;
                        div_a <= div_i;
                    end else begin
                        pre <= '0;
                        cnt <= cnt + 1'b1;
                        if (state == CH_HIGH && cnt == thr_a) state <= CH_LOW;
                    end
                end
                default: state <= CH_OFF;
            endcase
        end
    end

    // outputs
    always_comb pwm_o = (state == CH_HIGH);

    p_off_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !pwm_o);
    p_start_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_OFF && en_i) |=> pwm_o);
    p_full_duty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CH_HIGH && en_i && thr_a >= per_a) |=> pwm_o);
    p_hold_cfg_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state != CH_OFF && en_i && !wrap) |=>
            ($stable(per_a) && $stable(thr_a) && $stable(div_a)));
    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state != CH_OFF) |-> (cnt <= per_a));
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
    import pwm_bank_pkg::*;
#(
    parameter int NCH        = 8,
    parameter int AW         = 12,
    parameter int BASE       = 'h10,
    parameter int STRIDE     = 'h40,
    parameter bit ALT_DECODE = 1'b0,
    parameter int CNTW       = 13,
    parameter int DIVW       = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic           rd_en,
    input  logic [AW-1:0]  addr,
    input  logic [31:0]    wdata,
    output logic [31:0]    rdata,
    output logic [NCH-1:0] pwm_o
);
    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

    reg_kind_e       kind;
    logic [IW-1:0]   ch;
    logic [NCH-1:0]  en_q;
    logic [NCH-1:0]  keep_q;
    logic [DIVW-1:0] div_q [NCH];
    logic [CNTW-1:0] per_q [NCH];
    logic [CNTW-1:0] thr_q [NCH];

    pwm_addr_dec #(
        .NCH(NCH), .AW(AW), .BASE(BASE), .STRIDE(STRIDE), .ALT_DECODE(ALT_DECODE)
    ) u_dec (
        .addr_i(addr),
        .kind_o(kind),
        .ch_o  (ch)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         en_q <= '0;
        else if (wr_en && kind == RK_EN)    en_q <= wdata[NCH-1:0];
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                keep_q[g] <= 1'b0;
                div_q[g]  <= '0;
                per_q[g]  <= '0;
                thr_q[g]  <= '0;
            end else if (wr_en && ch == IW'(g)) begin
                if (kind == RK_CTRL) begin
                    keep_q[g] <= wdata[CTRL_KEEP];
                    div_q[g]  <= wdata[DIVW-1:0];
                end
                if (kind == RK_PER) per_q[g] <= wdata[CNTW-1:0];
                if (kind == RK_THR) thr_q[g] <= wdata[CNTW-1:0];
            end
        end

        pwm_chan #(.CNTW(CNTW), .DIVW(DIVW)) u_chan (
            .clk  (clk),
            .rst_n(rst_n),
            .en_i (en_q[g]),
            .div_i(div_q[g]),
            .per_i(per_q[g]),
            .thr_i(thr_q[g]),
            .pwm_o(pwm_o[g])
        );
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (kind)
                RK_EN:   rdata[NCH-1:0] = en_q;
                RK_CTRL: begin
                    rdata[CTRL_KEEP]  = keep_q[ch];
                    rdata[DIVW-1:0]   = div_q[ch];
                end
                RK_PER:  rdata[CNTW-1:0] = per_q[ch];
                RK_THR:  rdata[CNTW-1:0] = thr_q[ch];
                default: rdata = '0;
            endcase
        end
    end

    p_en_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && kind == RK_EN) |=> (en_q == $past(wdata[NCH-1:0])));
    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && kind == RK_NONE) |-> (rdata == '0));
endmodule

// File: tb/pwm_bank_tb.sv
module pwm_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_m = 1'b0, wr_a = 1'b0, rd_m = 1'b0, rd_a = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata_m, rdata_a;
    logic [7:0]  pwm_m;
    logic [3:0]  pwm_a;
    int          cyc = 0, tests = 0, fails = 0;

    always #10 clk = ~clk;

    pwm_bank u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_m), .rd_en(rd_m), .addr(addr),
        .wdata(wdata), .rdata(rdata_m), .pwm_o(pwm_m)
    );

    pwm_bank #(.NCH(4), .BASE('h100), .STRIDE('h100), .ALT_DECODE(1'b1)) u_alt (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_a), .rd_en(rd_a), .addr(addr),
        .wdata(wdata), .rdata(rdata_a), .pwm_o(pwm_a)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000) begin
            fails++;
            $display("FAIL watchdog: run hung, got cycle %0d exp < 150000", cyc);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    function automatic logic [11:0] wa(bit alt, int ch, int ofs);
        return alt ? 12'('h100 + ch * 'h100 + ofs) : 12'('h10 + ch * 'h40 + ofs);
    endfunction
    function automatic int exp_hi(int t, int p, int d);
        return ((t < p ? t : p) + 1) << d;
    endfunction
    function automatic int exp_per(int p, int d);
        return (p + 1) << d;
    endfunction

    task automatic chk(string req, int got, int exp);
        tests++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: got %0h exp %0h", req, got, exp);
        end
    endtask

    task automatic wr(bit alt, logic [11:0] a, logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d;
        if (alt) wr_a = 1'b1; else wr_m = 1'b1;
        @(negedge clk);
        wr_a = 1'b0; wr_m = 1'b0;
    endtask

    task automatic rd(bit alt, logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        if (alt) rd_a = 1'b1; else rd_m = 1'b1;
        #1;
        d = alt ? rdata_a : rdata_m;
        rd_a = 1'b0; rd_m = 1'b0;
    endtask

    task automatic wait_lvl(bit alt, int ch, bit val, output int stamp);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (((alt ? pwm_a[ch] : pwm_m[ch]) != val) && n < 5000);
        if (n >= 5000) chk("wait timeout", n, 0);
        stamp = cyc;
    endtask

    task automatic measure(bit alt, int ch, output int hi, output int per);
        int s, s0, f, s1;
        wait_lvl(alt, ch, 1'b1, s);
        wait_lvl(alt, ch, 1'b0, s);
        wait_lvl(alt, ch, 1'b1, s0);
        wait_lvl(alt, ch, 1'b0, f);
        wait_lvl(alt, ch, 1'b1, s1);
        hi = f - s0;
        per = s1 - s0;
    endtask

    task automatic setup(int ch, int d, int p, int t);
        wr(0, 12'h000, 32'h0);
        wr(0, wa(0, ch, 'h00), 32'h8000 | d);
        wr(0, wa(0, ch, 'h2C), p);
        wr(0, wa(0, ch, 'h30), t);
        wr(0, 12'h000, 32'h1 << ch);
    endtask

    task automatic run_case(string req, int ch, int d, int p, int t);
        int hi, per, lows;
        setup(ch, d, p, t);
        if (t >= p) begin
            lows = 0;
            repeat (2 * exp_per(p, d) + 4) begin
                @(negedge clk);
                if (!pwm_m[ch]) lows++;
            end
            chk({req, " R6 constant high"}, lows, 0);
        end else begin
            measure(0, ch, hi, per);
            chk({req, " R5 high time"}, hi, exp_hi(t, p, d));
            chk({req, " R4 period"}, per, exp_per(p, d));
        end
    endtask

    initial begin
        logic [31:0] d;
        int hi, per, s0, s1, f;
        void'($urandom(32'd5171));
        repeat (3) @(negedge clk);
        chk("R7 reset outputs low", int'(pwm_m), 0);
        rst_n = 1'b1;

        // R1 run mask
        rd(0, 12'h000, d); chk("R1 reset mask", d, 0);
        wr(0, 12'h000, 32'hFFFF_FFFF);
        rd(0, 12'h000, d); chk("R1 mask readback", d, 32'hFF);
        wr(0, 12'h000, 32'h0);

        // R3 control bits
        wr(0, wa(0, 5, 'h00), 32'hFFFF_FFFF);
        rd(0, wa(0, 5, 'h00), d); chk("R3 control readback", d, 32'h8007);
        wr(0, wa(0, 5, 'h00), 32'h0000_8002);
        rd(0, wa(0, 5, 'h00), d); chk("R3 control bit15+div", d, 32'h8002);

        // R2 / R4 / R5 register widths and window placement
        wr(0, wa(0, 7, 'h2C), 32'hFFFF_FFFF);
        rd(0, wa(0, 7, 'h2C), d); chk("R4 period width", d, 32'h1FFF);
        wr(0, wa(0, 7, 'h30), 32'h0000_2345);
        rd(0, wa(0, 7, 'h30), d); chk("R5 high width", d, 32'h0345);
        rd(0, wa(0, 6, 'h2C), d); chk("R2 neighbour window untouched", d, 0);

        // R10 unmapped
        wr(0, wa(0, 7, 'h04), 32'hFFFF_FFFF);
        rd(0, wa(0, 7, 'h04), d); chk("R10 hole reads zero", d, 0);
        rd(0, wa(0, 7, 'h2C), d); chk("R10 hole write ignored", d, 32'h1FFF);
        wr(0, wa(0, 8, 'h00), 32'hFFFF_FFFF);
        rd(0, wa(0, 8, 'h00), d); chk("R10 beyond last channel", d, 0);
        rd(0, 12'h00C, d); chk("R10 below base", d, 0);
        rd(0, wa(0, 0, 'h00), d); chk("R10 ch0 ctrl unchanged", d, 0);

        // R7 start and stop timing
        wr(0, wa(0, 2, 'h2C), 9);
        wr(0, wa(0, 2, 'h30), 3);
        wr(0, 12'h000, 32'h4);
        chk("R7 low in edge that stores run bit", int'(pwm_m[2]), 0);
        @(negedge clk);
        chk("R7 high one edge later", int'(pwm_m[2]), 1);
        measure(0, 2, hi, per);
        chk("R5 high time ch2", hi, 4);
        chk("R4 period ch2", per, 10);
        wr(0, 12'h000, 32'h0);
        f = 0;
        repeat (30) begin
            @(negedge clk);
            if (pwm_m[2]) f++;
        end
        chk("R7 stopped channel low", f, 0);

        // R6 coincidence of fall and wrap
        run_case("T==P", 1, 1, 3, 3);
        run_case("T==P d0", 4, 0, 1, 1);
        run_case("T>P", 3, 2, 5, 12);

        // R3 divider extremes
        run_case("R3 div 128", 0, 7, 1, 0);
        run_case("R3 div 1", 6, 0, 2, 0);

        // R8 update lands at boundary
        setup(0, 0, 19, 4);
        wait_lvl(0, 0, 1'b0, s0);
        wait_lvl(0, 0, 1'b1, s0);
        wr(0, wa(0, 0, 'h2C), 9);
        wr(0, wa(0, 0, 'h30), 2);
        wait_lvl(0, 0, 1'b0, f);
        chk("R8 old high time kept", f - s0, 5);
        wait_lvl(0, 0, 1'b1, s1);
        chk("R8 old period kept", s1 - s0, 20);
        wait_lvl(0, 0, 1'b0, f);
        chk("R8 new high time", f - s1, 3);
        wait_lvl(0, 0, 1'b1, s0);
        chk("R8 new period", s0 - s1, 10);

        // random cases
        for (int i = 0; i < 10; i++) begin
            int ch, dv, p, t;
            ch = int'($urandom_range(7, 0));
            dv = int'($urandom_range(2, 0));
            p  = int'($urandom_range(40, 1));
            t  = int'($urandom_range(p + 5, 0));
            run_case("random", ch, dv, p, t);
        end
        wr(0, 12'h000, 32'h0);

        // R9 alternate decode
        wr(1, wa(1, 3, 'h30), 32'h123);
        wr(1, wa(1, 3, 'h34), 32'h45);
        rd(1, wa(1, 3, 'h30), d); chk("R9 ch3 period at +0x30", d, 32'h123);
        rd(1, wa(1, 3, 'h34), d); chk("R9 ch3 high at +0x34", d, 32'h45);
        rd(1, wa(1, 3, 'h2C), d); chk("R9 ch3 +0x2C unmapped", d, 0);
        wr(1, wa(1, 1, 'h30), 32'h77);
        wr(1, wa(1, 1, 'h2C), 32'h99);
        rd(1, wa(1, 1, 'h30), d); chk("R9 ch1 high at +0x30", d, 32'h77);
        rd(1, wa(1, 1, 'h2C), d); chk("R9 ch1 period at +0x2C", d, 32'h99);
        wr(1, 12'h000, 32'h8);
        measure(1, 3, hi, per);
        chk("R9 ch3 high time", hi, 'h46);
        chk("R9 ch3 period", per, 'h124);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule